// File: doc/BRIEF.md
# Region-Based Bus Access Guard

This block sits in front of one or more slave ports of an on-chip bus fabric and decides, for every request that reaches those ports, whether it may proceed. Software fills a table of region descriptors through a small word-addressed register interface. Each descriptor gives a lower and an upper address bound and a rights word that lists, for each bus master, which kinds of access it may make inside that window. Each request presents its address, the ID of the master, the access kind (read, write or instruction fetch) and whether it runs in supervisor or user mode.

The decision is made combinationally from the held request. It is registered, so the slave sees the grant, or the requester sees the error, one clock after the request is presented. A request that fails the check is never granted. The failing port records the fault in its own 64-bit record (address plus an information word), and later faults overwrite earlier ones. After reset the guard is switched off and lets everything through until software sets the enable bit.

Descriptor validity is kept by hardware. Any write to a bound or to the main rights word takes the descriptor out of use. A write to its control word puts it back in use. A second, rights-only address for each descriptor lets software change permissions without disturbing the bounds or validity.

Top module: `mem_guard`

## Requirements
- R1: After reset the enable bit (word 0x00 bit 0) reads 0, every descriptor control word (0x40+4r+3, bit 0 = in use) reads 0, every port status word (0x10+4p+2) reads 0, and grant and err are low.
- R2: While enable is 0, every request (req_valid high) produces grant=1 and err=0 one clock later, whatever its address, master or kind.
- R3: A descriptor hits an address when it is in use and addr[31:5] lies between lower[31:5] and upper[31:5] inclusive. The lower bound is rounded down to its 32-byte line and the upper bound covers the last byte of its line.
- R4: For master 0 (the processor core), the rights bits are: 0 user read, 1 user write, 2 user fetch, 3 supervisor read, 4 supervisor write, 5 supervisor fetch. Kind codes are 0 read, 1 write, 2 fetch; code 3 is always denied.
- R5: A master m ≥ 1 is governed by rights bit 6+2(m-1) for reads and 7+2(m-1) for writes, ignoring the privilege input. A fetch by such a master is always denied.
- R6: When the address hits several descriptors, the request is granted if any one of them permits it.
- R7: With enable set, a request that hits no descriptor, or that every hit denies, gives err=1 and grant=0 one clock later. A permitted request gives grant=1 and err=0. With req_valid low, both outputs are 0 one clock later.
- R8: On a fault, the port's record takes the address (word 0x10+4p) and an information word (0x10+4p+1). That word holds bits[15:0] with one bit per descriptor that hit but denied, bits[17:16] the kind, bit 18 supervisor, and bits[24+] the master ID. A newer fault replaces the older record.
- R9: A fault sets the port's status flag (word 0x10+4p+2, bit 0). Writing 1 to that bit clears it, writing 0 has no effect, and a fault in the same cycle as the clear wins.
- R10: Writing a descriptor's lower bound (+0), upper bound (+1) or rights word (+2) takes it out of use. Writing its control word (+3), with any data, puts it in use.
- R11: Writing the alternate rights address 0x80+r replaces descriptor r's rights word, leaving its bounds and in-use bit unchanged.
- R12: A fault on one port leaves the records and status of the other ports unchanged.
- R13: Bounds, rights and enable read back the last value written, through the same addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PORTS | Request present on each guarded port |
| req_addr | input | NUM_PORTS×32 | Request byte address per port |
| req_mst | input | NUM_PORTS×MST_W | Master ID per port |
| req_kind | input | NUM_PORTS×2 | Access kind: 0 read, 1 write, 2 fetch |
| req_sup | input | NUM_PORTS | 1 = supervisor mode, 0 = user mode |
| grant | output | NUM_PORTS | Registered: request forwarded to slave |
| err | output | NUM_PORTS | Registered: request refused with error response |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from cfg_addr) |

## Verification
The hardest case to reach from the ports is a set of overlapping descriptors where a grant from one must override a denial from another. The per-descriptor detail bits have to show exactly which hits denied. A second hard case is a descriptor that software has half rewritten. The bench builds two overlapping windows with different rights, drives accesses into the shared part and into each private part, and then rewrites single words of a descriptor to confirm that it drops out of use until its control word is written. A long random phase on both ports, confined to an address range around those windows, then compares every cycle against a behavioural model.

// File: rtl/mg_pkg.sv
package mg_pkg;

    localparam int ADDR_W   = 32;
    localparam int LINE_LSB = 5;

    typedef enum logic [1:0] {
        ACC_RD = 2'd0,
        ACC_WR = 2'd1,
        ACC_EX = 2'd2
    } acc_e;

    typedef struct packed {
        logic [31:0] lo;
        logic [31:0] hi;
        logic [31:0] rights;
        logic        on;
    } desc_t;

    typedef struct packed {
        logic        grant;
        logic        err;
        logic [31:0] addr;
        logic [31:0] info;
        logic        flag;
    } rec_t;

    // Decide whether one rights word allows the given access.
    function automatic logic right_bit(logic [31:0] rights, int unsigned mst,
                                       logic [1:0] kind, logic sup);
        int unsigned idx;
        if (kind == 2'd3) return 1'b0;
        if (mst == 0) begin
            idx = (sup ? 3 : 0) + 32'(kind);
            return rights[idx[4:0]];
        end
        if (kind == ACC_EX) return 1'b0;
        idx = 6 + 2 * (mst - 1) + 32'(kind);
        return (idx < 32) ? rights[idx[4:0]] : 1'b0;
    endfunction

endpackage

// File: rtl/mg_region.sv
module mg_region
    import mg_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int MST_W     = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_lo,
    input  logic                              wr_hi,
    input  logic                              wr_rights,
    input  logic                              wr_alias,
    input  logic                              wr_ctrl,
    input  logic [31:0]                       wdata,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  req_addr,
    input  logic [NUM_PORTS-1:0][MST_W-1:0]   req_mst,
    input  logic [NUM_PORTS-1:0][1:0]         req_kind,
    input  logic [NUM_PORTS-1:0]              req_sup,
    output logic [NUM_PORTS-1:0]              hit,
    output logic [NUM_PORTS-1:0]              allow,
    output desc_t                             desc
);

    desc_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        if (wr_lo) begin
            d_d.lo = wdata;
            d_d.on = 1'b0;
        end
        if (wr_hi) begin
            d_d.hi = wdata;
            d_d.on = 1'b0;
        end
        if (wr_rights) begin
            d_d.rights = wdata;
            d_d.on     = 1'b0;
        end
        if (wr_alias) d_d.rights = wdata;
        if (wr_ctrl)  d_d.on     = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign desc = d_q;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [ADDR_W-1:LINE_LSB] line;
        assign line     = req_addr[p][ADDR_W-1:LINE_LSB];
        assign hit[p]   = d_q.on &&
                          (line >= d_q.lo[ADDR_W-1:LINE_LSB]) &&
                          (line <= d_q.hi[ADDR_W-1:LINE_LSB]);
        assign allow[p] = hit[p] &&
                          right_bit(d_q.rights, 32'(req_mst[p]), req_kind[p], req_sup[p]);
    end

    // R10
    bound_write_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_hi || wr_rights) && !wr_ctrl |=> !desc.on);
    // R10
    ctrl_write_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> desc.on);
    // R11
    alias_keeps_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_alias && !wr_lo && !wr_hi && !wr_rights && !wr_ctrl |=> desc.on == $past(desc.on));
    // R11
    alias_keeps_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_alias && !wr_lo && !wr_hi |=> $stable(desc.lo) && $stable(desc.hi));

endmodule

// File: rtl/mg_port.sv
module mg_port
    import mg_pkg::*;
#(
    parameter int NUM_REG = 16,
    parameter int MST_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [MST_W-1:0]   req_mst,
    input  logic [1:0]         req_kind,
    input  logic               req_sup,
    input  logic [NUM_REG-1:0] hit,
    input  logic [NUM_REG-1:0] allow,
    input  logic               clr,
    output logic               grant,
    output logic               err,
    output logic [31:0]        rec_addr,
    output logic [31:0]        rec_info,
    output logic               rec_flag
);

    rec_t        s_d, s_q;
    logic        deny;
    logic [15:0] detail;

    always_comb begin
        deny                   = enable && req_valid && !(|allow);
        detail                 = '0;
        detail[NUM_REG-1:0]    = hit & ~allow;
        s_d                    = s_q;
        s_d.grant              = req_valid && !deny;
        s_d.err                = deny;
        if (clr) s_d.flag      = 1'b0;
        if (deny) begin
            s_d.addr              = req_addr;
            s_d.info              = '0;
            s_d.info[15:0]        = detail;
            s_d.info[17:16]       = req_kind;
            s_d.info[18]          = req_sup;
            s_d.info[24 +: MST_W] = req_mst;
            s_d.flag              = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign grant    = s_q.grant;
    assign err      = s_q.err;
    assign rec_addr = s_q.addr;
    assign rec_info = s_q.info;
    assign rec_flag = s_q.flag;

    // R2
    off_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable && req_valid |=> grant && !err);
    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !grant && !err);
    // R6
    any_allow_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (|allow) |=> grant && !err);
    // R8
    fault_addr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> rec_addr == $past(req_addr));
    // R9
    fault_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> rec_flag);

endmodule

// File: rtl/mem_guard.sv
module mem_guard
    import mg_pkg::*;
#(
    parameter  int NUM_REG     = 16,
    parameter  int NUM_PORTS   = 2,
    parameter  int NUM_MASTERS = 4,
    localparam int MST_W       = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PORTS-1:0]              req_valid,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  req_addr,
    input  logic [NUM_PORTS-1:0][MST_W-1:0]   req_mst,
    input  logic [NUM_PORTS-1:0][1:0]         req_kind,
    input  logic [NUM_PORTS-1:0]              req_sup,
    output logic [NUM_PORTS-1:0]              grant,
    output logic [NUM_PORTS-1:0]              err,
    input  logic                              cfg_we,
    input  logic [7:0]                        cfg_addr,
    input  logic [31:0]                       cfg_wdata,
    output logic [31:0]                       cfg_rdata
);

    localparam int REC_BASE   = 8'h10;
    localparam int DESC_BASE  = 8'h40;
    localparam int ALIAS_BASE = 8'h80;

    typedef struct packed { logic en; } glob_t;

    glob_t g_d, g_q;

    desc_t                              desc  [NUM_REG];
    logic [NUM_REG-1:0][NUM_PORTS-1:0]  hit_rp, allow_rp;
    logic [NUM_PORTS-1:0][NUM_REG-1:0]  hit_pr, allow_pr;
    logic [NUM_PORTS-1:0][31:0]         rec_addr, rec_info;
    logic [NUM_PORTS-1:0]               rec_flag;
    logic [NUM_PORTS-1:0]               clr;

    always_comb begin
        g_d = g_q;
        if (cfg_we && cfg_addr == 8'h00) g_d.en = cfg_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        mg_region #(.NUM_PORTS(NUM_PORTS), .MST_W(MST_W)) u_region (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (cfg_we && cfg_addr == 8'(DESC_BASE + 4 * r)),
            .wr_hi     (cfg_we && cfg_addr == 8'(DESC_BASE + 4 * r + 1)),
            .wr_rights (cfg_we && cfg_addr == 8'(DESC_BASE + 4 * r + 2)),
            .wr_alias  (cfg_we && cfg_addr == 8'(ALIAS_BASE + r)),
            .wr_ctrl   (cfg_we && cfg_addr == 8'(DESC_BASE + 4 * r + 3)),
            .wdata     (cfg_wdata),
            .req_addr  (req_addr),
            .req_mst   (req_mst),
            .req_kind  (req_kind),
            .req_sup   (req_sup),
            .hit       (hit_rp[r]),
            .allow     (allow_rp[r]),
            .desc      (desc[r])
        );
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_tr
            assign hit_pr[p][r]   = hit_rp[r][p];
            assign allow_pr[p][r] = allow_rp[r][p];
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign clr[p] = cfg_we && cfg_wdata[0] && cfg_addr == 8'(REC_BASE + 4 * p + 2);
        mg_port #(.NUM_REG(NUM_REG), .MST_W(MST_W)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (g_q.en),
            .req_valid (req_valid[p]),
            .req_addr  (req_addr[p]),
            .req_mst   (req_mst[p]),
            .req_kind  (req_kind[p]),
            .req_sup   (req_sup[p]),
            .hit       (hit_pr[p]),
            .allow     (allow_pr[p]),
            .clr       (clr[p]),
            .grant     (grant[p]),
            .err       (err[p]),
            .rec_addr  (rec_addr[p]),
            .rec_info  (rec_info[p]),
            .rec_flag  (rec_flag[p])
        );
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == 8'h00) cfg_rdata[0] = g_q.en;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (cfg_addr == 8'(REC_BASE + 4 * p))     cfg_rdata    = rec_addr[p];
            if (cfg_addr == 8'(REC_BASE + 4 * p + 1)) cfg_rdata    = rec_info[p];
            if (cfg_addr == 8'(REC_BASE + 4 * p + 2)) cfg_rdata[0] = rec_flag[p];
        end
        for (int r = 0; r < NUM_REG; r++) begin
            if (cfg_addr == 8'(DESC_BASE + 4 * r))     cfg_rdata    = desc[r].lo;
            if (cfg_addr == 8'(DESC_BASE + 4 * r + 1)) cfg_rdata    = desc[r].hi;
            if (cfg_addr == 8'(DESC_BASE + 4 * r + 2)) cfg_rdata    = desc[r].rights;
            if (cfg_addr == 8'(ALIAS_BASE + r))        cfg_rdata    = desc[r].rights;
            if (cfg_addr == 8'(DESC_BASE + 4 * r + 3)) cfg_rdata[0] = desc[r].on;
        end
    end

    initial begin
        param_fit_chk: assert (NUM_REG <= 16 && NUM_PORTS <= 4 && NUM_MASTERS <= 14);
    end

    // R7
    one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(grant & err)));

endmodule

// File: tb/tb_mem_guard.sv
module tb_mem_guard;

    localparam int CLK_NS = 10;
    localparam int NR = 16;
    localparam int NP = 2;

    logic                 clk = 0;
    logic                 rst_n = 0;
    logic [NP-1:0]        req_valid = '0;
    logic [NP-1:0][31:0]  req_addr = '0;
    logic [NP-1:0][1:0]   req_mst = '0;
    logic [NP-1:0][1:0]   req_kind = '0;
    logic [NP-1:0]        req_sup = '0;
    logic [NP-1:0]        grant, err;
    logic                 cfg_we = 0;
    logic [7:0]           cfg_addr = '0;
    logic [31:0]          cfg_wdata = '0;
    logic [31:0]          cfg_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS / 2) clk = ~clk;

    mem_guard #(.NUM_REG(NR), .NUM_PORTS(NP), .NUM_MASTERS(4)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_mst(req_mst), .req_kind(req_kind), .req_sup(req_sup),
        .grant(grant), .err(err), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_lo [NR];
    logic [31:0] m_hi [NR];
    logic [31:0] m_rt [NR];
    bit          m_on [NR];
    bit          m_en;
    logic [31:0] m_raddr [NP];
    logic [31:0] m_rinfo [NP];
    bit          m_rflag [NP];
    bit          exp_g [NP];
    bit          exp_e [NP];

    function automatic bit permits(int r, int m, int k, bit s);
        if (k == 3) return 0;
        if (m == 0) begin
            case (k)
                0: return s ? m_rt[r][3] : m_rt[r][0];
                1: return s ? m_rt[r][4] : m_rt[r][1];
                default: return s ? m_rt[r][5] : m_rt[r][2];
            endcase
        end
        if (k == 2) return 0;
        return m_rt[r][6 + 2 * (m - 1) + k];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NR; r++) begin
                m_lo[r] = 0; m_hi[r] = 0; m_rt[r] = 0; m_on[r] = 0;
            end
            m_en = 0;
            for (int p = 0; p < NP; p++) begin
                m_raddr[p] = 0; m_rinfo[p] = 0; m_rflag[p] = 0;
                exp_g[p] = 0; exp_e[p] = 0;
            end
        end else begin
            for (int p = 0; p < NP; p++) begin
                logic [15:0] hits, oks;
                bit fault;
                hits = 0; oks = 0;
                for (int r = 0; r < NR; r++) begin
                    if (m_on[r] && (req_addr[p] >> 5) >= (m_lo[r] >> 5) &&
                        (req_addr[p] >> 5) <= (m_hi[r] >> 5)) begin
                        hits[r] = 1;
                        if (permits(r, req_mst[p], req_kind[p], req_sup[p])) oks[r] = 1;
                    end
                end
                fault = m_en && req_valid[p] && (oks == 0);
                exp_g[p] = req_valid[p] && !fault;
                exp_e[p] = fault;
                if (cfg_we && cfg_addr == 8'(16 + 4 * p + 2) && cfg_wdata[0]) m_rflag[p] = 0;
                if (fault) begin
                    m_raddr[p] = req_addr[p];
                    m_rinfo[p] = (32'(req_mst[p]) << 24) | (32'(req_sup[p]) << 18) |
                                 (32'(req_kind[p]) << 16) | 32'(hits & ~oks);
                    m_rflag[p] = 1;
                end
            end
            if (cfg_we) begin
                if (cfg_addr == 8'h00) m_en = cfg_wdata[0];
                for (int r = 0; r < NR; r++) begin
                    if (cfg_addr == 8'(64 + 4 * r))     begin m_lo[r] = cfg_wdata; m_on[r] = 0; end
                    if (cfg_addr == 8'(64 + 4 * r + 1)) begin m_hi[r] = cfg_wdata; m_on[r] = 0; end
                    if (cfg_addr == 8'(64 + 4 * r + 2)) begin m_rt[r] = cfg_wdata; m_on[r] = 0; end
                    if (cfg_addr == 8'(64 + 4 * r + 3)) m_on[r] = 1;
                    if (cfg_addr == 8'(128 + r))        m_rt[r] = cfg_wdata;
                end
            end
        end
    end

    // Cycle-by-cycle comparison of both ports (R2, R6, R7).
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < NP; p++) begin
                checks++;
                if (grant[p] !== exp_g[p] || err[p] !== exp_e[p]) begin
                    errors++;
                    $display("FAIL R7 model port%0d: grant=%0b err=%0b expected grant=%0b err=%0b",
                             p, grant[p], err[p], exp_g[p], exp_e[p]);
                end
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    task automatic access(int p, logic [31:0] a, int m, int k, bit s, bit exp_err, string tag);
        @(negedge clk);
        req_valid[p] = 1; req_addr[p] = a; req_mst[p] = 2'(m);
        req_kind[p] = 2'(k); req_sup[p] = s;
        @(negedge clk);
        check(tag, {30'b0, grant[p], err[p]}, {30'b0, !exp_err, exp_err});
        req_valid[p] = 0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_NS * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check("R1 outputs", {30'b0, grant[0] | grant[1], err[0] | err[1]}, 0);
        rd(8'h00, 0, "R1 enable");
        rd(8'h43, 0, "R1 descriptor0 unused");
        rd(8'h12, 0, "R1 status port0");

        // R2
        access(0, 32'h2000_0000, 2, 2, 0, 0, "R2 disabled fetch passes");
        access(1, 32'h0000_0000, 3, 1, 0, 0, "R2 disabled write passes");

        // Descriptor 0: user read for core, read/write for master 1
        wr(8'h40, 32'h1000_0010);
        wr(8'h41, 32'h1000_0FE3);
        wr(8'h42, 32'h0000_00C1);
        wr(8'h43, 0);
        rd(8'h43, 1, "R10 control write arms");
        wr(8'h00, 1);

        access(0, 32'h1000_0000, 0, 0, 0, 0, "R3 lower rounded down");
        access(0, 32'h1000_0FFF, 0, 0, 0, 0, "R3 upper inclusive to line end");
        access(0, 32'h1000_1000, 0, 0, 0, 1, "R3 first byte past upper");
        access(0, 32'h0FFF_FFE0, 0, 0, 0, 1, "R7 no region hit");
        access(0, 32'h1000_0100, 0, 1, 0, 1, "R4 user write denied");
        access(0, 32'h1000_0100, 0, 0, 1, 1, "R4 supervisor read own bit");
        access(0, 32'h1000_0100, 1, 1, 0, 0, "R5 master1 write");
        access(0, 32'h1000_0100, 1, 2, 0, 1, "R5 fetch by noncore denied");
        access(0, 32'h1000_0100, 2, 0, 0, 1, "R5 master2 without bits");

        // Descriptor 1 overlaps upper half of descriptor 0: core user write
        wr(8'h44, 32'h1000_0800);
        wr(8'h45, 32'h1000_1FFF);
        wr(8'h46, 32'h0000_0002);
        wr(8'h47, 0);
        access(0, 32'h1000_0900, 0, 1, 0, 0, "R6 overlap write granted by second");
        access(0, 32'h1000_0900, 0, 0, 0, 0, "R6 overlap read granted by first");
        access(0, 32'h1000_1800, 0, 0, 0, 1, "R7 single hit denies");
        rd(8'h10, 32'h1000_1800, "R8 fault address");
        rd(8'h11, 32'h0000_0002, "R8 info detail bit1");
        rd(8'h12, 1, "R9 flag set");
        access(0, 32'h1000_0900, 0, 2, 1, 1, "R8 both hits deny");
        rd(8'h10, 32'h1000_0900, "R8 newer address");
        rd(8'h11, 32'h0006_0003, "R8 newer info overwrites");

        wr(8'h12, 0);
        rd(8'h12, 1, "R9 zero write ignored");
        wr(8'h12, 1);
        rd(8'h12, 0, "R9 one write clears");
        rd(8'h10, 32'h1000_0900, "R9 clear keeps address");

        // R12
        access(1, 32'h3000_0000, 3, 1, 0, 1, "R12 port1 fault");
        rd(8'h12, 0, "R12 port0 status untouched");
        rd(8'h10, 32'h1000_0900, "R12 port0 address untouched");
        rd(8'h16, 1, "R12 port1 status");
        rd(8'h14, 32'h3000_0000, "R12 port1 address");
        rd(8'h15, 32'h0301_0000, "R12 port1 info");

        // R10
        wr(8'h44, 32'h1000_0800);
        rd(8'h47, 0, "R10 lower write drops");
        access(0, 32'h1000_1800, 0, 1, 0, 1, "R10 dropped region unused");
        wr(8'h47, 0);
        access(0, 32'h1000_1800, 0, 1, 0, 0, "R10 rearmed region used");
        wr(8'h45, 32'h1000_1FFF);
        rd(8'h47, 0, "R10 upper write drops");
        wr(8'h47, 0);
        wr(8'h46, 32'h0000_0002);
        rd(8'h47, 0, "R10 rights write drops");
        wr(8'h47, 0);

        // R11
        wr(8'h80, 32'h0000_00C5);
        rd(8'h43, 1, "R11 alias keeps in-use");
        rd(8'h42, 32'h0000_00C5, "R11 rights replaced");
        rd(8'h40, 32'h1000_0010, "R13 lower unchanged");
        rd(8'h41, 32'h1000_0FE3, "R13 upper readback");
        access(0, 32'h1000_0100, 0, 2, 0, 0, "R11 fetch now granted");

        // R2 again, then R13 enable readback
        wr(8'h00, 0);
        rd(8'h00, 0, "R13 enable readback");
        access(0, 32'h0000_0040, 2, 2, 0, 0, "R2 disabled again");
        wr(8'h00, 1);

        // Random traffic on both ports
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            for (int p = 0; p < NP; p++) begin
                req_valid[p] = 1'($urandom_range(0, 1));
                req_addr[p]  = 32'h0FFF_FF00 + 32'($urandom_range(0, 32'h2400));
                req_mst[p]   = 2'($urandom_range(0, 3));
                req_kind[p]  = 2'($urandom_range(0, 2));
                req_sup[p]   = 1'($urandom_range(0, 1));
            end
        end
        @(negedge clk);
        req_valid = '0;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            rd(8'(16 + 4 * p), m_raddr[p], "R8 random address");
            rd(8'(16 + 4 * p + 1), m_rinfo[p], "R8 random info");
            rd(8'(16 + 4 * p + 2), 32'(m_rflag[p]), "R9 random flag");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule